// File: doc/BRIEF.md
# Key-Sequence Write Guard

The block sits beside a bank of configuration registers and keeps stray bus writes from changing them. All protected registers start out locked. Software opens them by writing two specific byte values, one after the other, to a dedicated key address. After that, every write to a protected address is passed on as a one-hot write enable. The bank stays open until any other value is written to the key address.

The write port is a plain single-cycle strobe with address and data. Each write is accepted in the cycle its strobe is high, and there is no back-pressure. For this reason the port has no valid/ready pair. Only one protected register is actually built here: a scratch register used for test. It makes the effect of the guard visible on the read port. The other protected registers belong to neighbouring logic, which consumes the enable vector.

Top module: `wp_key_guard`

## Requirements
- R1: After reset the guard is locked (`unlocked`=0), `prot_we` is zero and the scratch register reads 0.
- R2: Two key-address writes open the guard: first low byte 0xCA, then low byte 0x53. `unlocked` rises on the clock edge that takes the second write. When 0xCA is written more than once, the most recent 0xCA write is the one that arms.
- R3: A 0x53 key write that does not directly follow a 0xCA key write leaves the guard locked. A wrong value in second place returns it to locked, so a 0x53 written after that does not unlock.
- R4: While open, any key-address write relocks the guard on that write's clock edge. This covers 0xFF, 0x53 and every other value. A 0xCA write also relocks, and it arms a new sequence.
- R5: Only bits [7:0] of a key write are compared with the key values. Bits [31:8] have no effect.
- R6: Writes to non-key addresses between the two key writes do not break the sequence.
- R7: While locked, `prot_we` stays zero for every address. A write to the scratch register address (2) leaves its contents unchanged.
- R8: While open, a write to protected address a (0 to 7) raises `prot_we` bit a alone, in the same cycle as the strobe. A write to address 2 loads the scratch register on that clock edge.
- R9: Reading the key address (9) returns zero. Reading address 2 returns the scratch register. Any other read address returns zero.
- R10: Writes to addresses 8 to 15 other than the key address never raise `prot_we` and do not change the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |
| unlocked | output | 1 | High while protected writes are allowed |
| prot_we | output | 8 | One-hot write enable for protected addresses 0 to 7 |

## Verification
If the sequencer held a wrong state, `unlocked` would show it at the first negative edge after the key write. Examples are an armed state that survived a wrong byte, or an open state that ignored a relock. `prot_we` would then follow in the same cycle as the next protected write. A corrupted decode or gating path shows up at once in the enable vector. It also shows one read later, as a scratch register value that changed or failed to change. The sweeps cover every byte value in the first-key slot, in the second-key slot and as a relock write, together with every address in both lock states.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam int unsigned KEY_BYTE_W = 8;
endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned PROT_COUNT = 8,
  parameter int unsigned KEY_ADDR   = 9
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  key_hit,
  output logic [PROT_COUNT-1:0] prot_hit
);
  assign key_hit = (addr == ADDR_W'(KEY_ADDR));

  for (genvar i = 0; i < PROT_COUNT; i++) begin : g_hit
    assign prot_hit[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/wp_key_seq.sv
module wp_key_seq
  import wp_pkg::*;
#(
  parameter logic [KEY_BYTE_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [KEY_BYTE_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  key_wr,
  input  logic [KEY_BYTE_W-1:0] key_byte,
  output logic                  unlocked
);
  key_state_e st, st_nxt;

  always_comb begin
    st_nxt = st;
    if (key_wr) begin
      if (key_byte == KEY_FIRST)                           st_nxt = KS_ARMED;
      else if (st == KS_ARMED && key_byte == KEY_SECOND)   st_nxt = KS_OPEN;
      else                                                 st_nxt = KS_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= KS_LOCKED;
    else        st <= st_nxt;
  end

  assign unlocked = (st == KS_OPEN);

  // opening needs an armed state plus the second key
  assert_open_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KS_OPEN && $past(st) != KS_OPEN) |->
      $past(st == KS_ARMED && key_wr && key_byte == KEY_SECOND));

  assert_armed_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KS_ARMED && $past(st) != KS_ARMED) |-> $past(key_wr && key_byte == KEY_FIRST));

  assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KS_OPEN && key_wr) |=> (st != KS_OPEN));

  assert_no_key_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(st));
endmodule

// File: rtl/wp_scratch_reg.sv
module wp_scratch_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/wp_key_guard.sv
module wp_key_guard
  import wp_pkg::*;
#(
  parameter int unsigned           ADDR_W     = 4,
  parameter int unsigned           DATA_W     = 32,
  parameter int unsigned           PROT_COUNT = 8,
  parameter int unsigned           KEY_ADDR   = 9,
  parameter int unsigned           TEST_ADDR  = 2,
  parameter logic [KEY_BYTE_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [KEY_BYTE_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  unlocked,
  output logic [PROT_COUNT-1:0] prot_we
);
  logic                  wr_key_hit;
  logic [PROT_COUNT-1:0] wr_prot_hit;
  logic                  key_wr;
  logic [DATA_W-1:0]     test_q;

  wp_addr_decode #(
    .ADDR_W(ADDR_W), .PROT_COUNT(PROT_COUNT), .KEY_ADDR(KEY_ADDR)
  ) u_wdec (
    .addr(wr_addr), .key_hit(wr_key_hit), .prot_hit(wr_prot_hit)
  );

  assign key_wr = wr_en & wr_key_hit;

  wp_key_seq #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_seq (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
    .key_byte(wr_data[KEY_BYTE_W-1:0]), .unlocked(unlocked)
  );

  assign prot_we = {PROT_COUNT{wr_en & unlocked}} & wr_prot_hit;

  wp_scratch_reg #(.WIDTH(DATA_W)) u_test (
    .clk(clk), .rst_n(rst_n), .we(prot_we[TEST_ADDR]), .d(wr_data), .q(test_q)
  );

  always_comb begin
    if (rd_addr == ADDR_W'(KEY_ADDR))       rd_data = '0;
    else if (rd_addr == ADDR_W'(TEST_ADDR)) rd_data = test_q;
    else                                    rd_data = '0;
  end

  assert_we_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prot_we));

  assert_blocked_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_en && wr_addr == ADDR_W'(TEST_ADDR)) |=> $stable(test_q));

  assert_far_addr_no_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(PROT_COUNT)) |-> (prot_we == '0));

  assert_far_addr_no_lock_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(PROT_COUNT) && wr_addr != ADDR_W'(KEY_ADDR))
      |=> $stable(unlocked));
endmodule

// File: tb/wp_key_guard_tb.sv
module wp_key_guard_tb_top;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int PC = 8;
  localparam logic [AW-1:0] KA = 4'd9;
  localparam logic [AW-1:0] TA = 4'd2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          unlocked;
  logic [PC-1:0] prot_we;
  logic [PC-1:0] seen_we;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wp_key_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .unlocked(unlocked), .prot_we(prot_we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #2 seen_we = prot_we;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic key(input logic [7:0] v);
    bus_wr(KA, {24'hA5C3F1, v});
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 unlocked", {31'd0, unlocked}, 32'd0);
    chk("R1 prot_we", {24'd0, prot_we}, 32'd0);
    rst_n = 1'b1;
    rd(TA, r);
    chk("R1 scratch", r, 32'd0);

    // R7 locked: every address blocked, scratch unchanged
    for (int a = 0; a < 16; a++) begin
      if (a == int'(KA)) continue;
      bus_wr(AW'(a), 32'hDEAD0000 + a);
      chk("R7 locked we", {24'd0, seen_we}, 32'd0);
      chk("R10 stays locked", {31'd0, unlocked}, 32'd0);
    end
    rd(TA, r);
    chk("R7 scratch held", r, 32'd0);

    // R2/R3 sweep of first-slot value
    for (int v = 0; v < 256; v++) begin
      key(8'hFF);
      key(8'(v));
      key(8'h53);
      chk("R2 first-slot sweep", {31'd0, unlocked}, {31'd0, v == 8'hCA});
    end

    // R2/R3 sweep of second-slot value and restart
    for (int v = 0; v < 256; v++) begin
      key(8'hFF);
      key(8'hCA);
      key(8'(v));
      chk("R2 second-slot sweep", {31'd0, unlocked}, {31'd0, v == 8'h53});
      key(8'h53);
      chk("R3 restart needed", {31'd0, unlocked}, {31'd0, v == 8'hCA});
    end

    // R4 any key write while open relocks
    for (int v = 0; v < 256; v++) begin
      key(8'hCA);
      key(8'h53);
      key(8'(v));
      chk("R4 relock", {31'd0, unlocked}, 32'd0);
    end

    // R5 upper bits ignored
    key(8'hFF);
    bus_wr(KA, 32'hFFFFFFCA);
    bus_wr(KA, 32'h12345653);
    chk("R5 low byte only", {31'd0, unlocked}, 32'd1);
    bus_wr(KA, 32'hCA53FF00);
    chk("R5 relock by low byte", {31'd0, unlocked}, 32'd0);

    // R6 interleaved writes
    key(8'hCA);
    bus_wr(4'd12, 32'h0000_0053);
    bus_wr(TA, 32'h1111_2222);
    chk("R6 blocked between keys", {24'd0, seen_we}, 32'd0);
    key(8'h53);
    chk("R6 sequence kept", {31'd0, unlocked}, 32'd1);
    rd(TA, r);
    chk("R7 scratch not written while armed", r, 32'd0);

    // R8/R10 open: address sweep
    for (int a = 0; a < 16; a++) begin
      if (a == int'(KA)) continue;
      bus_wr(AW'(a), 32'hC0DE0000 + a);
      chk("R8 open we", {24'd0, seen_we}, (a < PC) ? (32'd1 << a) : 32'd0);
      chk("R10 stays open", {31'd0, unlocked}, 32'd1);
    end
    rd(TA, r);
    chk("R8 scratch loaded", r, 32'hC0DE0002);

    // R9 reads
    rd(KA, r);
    chk("R9 key reads zero", r, 32'd0);
    rd(4'd5, r);
    chk("R9 other reads zero", r, 32'd0);

    // R7 relocked write to scratch ignored
    key(8'hFF);
    bus_wr(TA, 32'h0BAD0BAD);
    chk("R7 relocked we", {24'd0, seen_we}, 32'd0);
    rd(TA, r);
    chk("R7 scratch kept", r, 32'hC0DE0002);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule